// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash interface. It watches the asynchronous chip-enable, write-enable and output-enable strobes and brings them into the clock domain. It turns each qualified write into one address/data pair. It then follows the multi-cycle command protocol: two unlock writes come before every command, and erase commands need a second unlock pair. Each completed command produces a single-cycle event for the array and erase engine that follows.

The block also tracks what a read returns: array data, identification data, query data or operation status. While identification mode is active it supplies the identification word for the current address directly. Byte or word addressing is selected by a level input, and the unlock addresses change with it. A reset command is obeyed in every state except while an embedded operation is running normally.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write counts only when `ce_n` and `we_n` are both low while `oe_n` is high. The address is taken when that condition starts and the data when it ends. A strobe with `oe_n` low or `ce_n` high changes nothing and produces no event.
- R2: The unlock pair is data AA then 55. In word mode (`byte_mode`=0) the addresses are 555h then 2AAh, compared on address bits [10:0]. In byte mode they are AAAh then 555h, compared on bits [11:0]. The command cycle after the pair uses the first unlock address. Unlock writes at the other mode's addresses are ignored.
- R3: Unlock pair, then A0, then any write gives event PROGRAM carrying that write's address and data.
- R4: Unlock pair, 80, unlock pair, then 10 at the command address gives event CHIP_ERASE.
- R5: Unlock pair, 80, unlock pair, then 30 at any address gives event SECTOR_ERASE. `evt_sector` is address bits [19:16] in byte mode and [18:15] in word mode.
- R6: Unlock pair, then 90 gives event AUTOSEL and read mode 1. The mode persists across reads and other writes until a reset command.
- R7: In read mode 1, `id_data` depends on the offset (address bits [7:0] in word mode, bits [8:1] in byte mode). Offset 0 returns 00C2h. Offset 1 returns the device ID, or only its low byte in byte mode. Offset 2 returns 0 or 1 as the protect bit of the addressed sector. `id_data` is 0 in other modes.
- R8: From idle, a single write of 98 at address 55h (word) or AAh (byte) gives event CFI and read mode 2.
- R9: F0 at any address, when not blocked, gives event RESET, read mode 0 and a cleared sequence. This holds part way through a sequence, in identification or query mode, and while `op_fail` is high.
- R10: While blocked (`op_busy`=1 and `op_fail`=0), every write is ignored except B0, which gives SUSPEND. F0 and unlock writes have no effect.
- R11: From idle, B0 at any address gives SUSPEND and 30 at any address gives RESUME.
- R12: A write that breaks the expected pattern part way through a sequence returns the block to idle and read mode 0 without an event. A fresh sequence is then accepted.
- R13: `read_mode` is 3 (status) whenever `op_busy` or `op_fail` is high. Otherwise it is 0 array, 1 identification or 2 query.
- R14: `evt_valid` is a one-cycle pulse per accepted command. The `evt_cmd` codes are 1 PROGRAM, 2 CHIP_ERASE, 3 SECTOR_ERASE, 4 AUTOSEL, 5 CFI, 6 RESET, 7 SUSPEND, 8 RESUME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, asynchronous, active low |
| we_n | input | 1 | Write enable strobe, asynchronous, active low |
| oe_n | input | 1 | Output enable strobe, asynchronous, active low |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| addr | input | ADDR_W | Bus address (byte address in byte mode) |
| wdata | input | DATA_W | Write data bus |
| op_busy | input | 1 | Embedded program or erase is running |
| op_fail | input | 1 | Embedded operation has failed |
| sect_prot | input | NUM_SECT | Protect bit per sector |
| evt_valid | output | 1 | Command event pulse |
| evt_cmd | output | 4 | Command event code |
| evt_addr | output | ADDR_W | Address of the final command write |
| evt_data | output | DATA_W | Data of the final command write |
| evt_sector | output | SECT_W | Sector of `evt_addr` |
| read_mode | output | 2 | Current read mode |
| id_data | output | DATA_W | Identification word for `addr` |

## Verification
The bench targets the places where the two addressing modes differ. It sends a word-mode sequence built from byte-mode addresses. A decoder that masked the wrong number of address bits would accept it and issue a stray PROGRAM. It disqualifies a single unlock write by holding `oe_n` low or `ce_n` high. A design that ignored either strobe would complete the sequence and fire an event. It sends F0 while an operation is busy and again after a failure. A design without the state-dependent gate either drops the recovery reset or cuts into a running operation. A bad third cycle issued from identification mode must land in array mode, not stay stuck in identification.

// File: rtl/fcd_pkg.sv
// Package: shared encodings and the unlock-address compare for the command decoder.
// Assumes address bit 0 is the least significant bit of the bus address.
package fcd_pkg;

    typedef enum logic [3:0] {
        EV_NONE         = 4'd0,
        EV_PROGRAM      = 4'd1,
        EV_CHIP_ERASE   = 4'd2,
        EV_SECTOR_ERASE = 4'd3,
        EV_AUTOSEL      = 4'd4,
        EV_CFI          = 4'd5,
        EV_RESET        = 4'd6,
        EV_SUSPEND      = 4'd7,
        EV_RESUME       = 4'd8
    } fcd_evt_e;

    typedef enum logic [1:0] {
        RM_ARRAY   = 2'd0,
        RM_AUTOSEL = 2'd1,
        RM_CFI     = 2'd2,
        RM_STATUS  = 2'd3
    } fcd_rmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ESET, SQ_EUNL1, SQ_EUNL2
    } fcd_seq_e;

    localparam logic [7:0] CODE_KEY1    = 8'hAA;
    localparam logic [7:0] CODE_KEY2    = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_IDENT   = 8'h90;
    localparam logic [7:0] CODE_ESETUP  = 8'h80;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_SECT    = 8'h30;
    localparam logic [7:0] CODE_QUERY   = 8'h98;
    localparam logic [7:0] CODE_RESET   = 8'hF0;
    localparam logic [7:0] CODE_SUSPEND = 8'hB0;

    localparam logic [10:0] W_KEY1_ADR  = 11'h555;
    localparam logic [10:0] W_KEY2_ADR  = 11'h2AA;
    localparam logic [10:0] W_QUERY_ADR = 11'h055;
    localparam logic [11:0] B_KEY1_ADR  = 12'hAAA;
    localparam logic [11:0] B_KEY2_ADR  = 12'h555;
    localparam logic [11:0] B_QUERY_ADR = 12'h0AA;

    // Compare the low address bits against the word or byte magic value.
    function automatic logic adr_hit(input logic [11:0] a, input logic bm,
                                     input logic [10:0] wv, input logic [11:0] bv);
        return bm ? (a == bv) : (a[10:0] == wv);
    endfunction

endpackage

// File: rtl/fcd_write_qual.sv
// Module: brings the asynchronous strobes into the clock domain and forms
// one write pulse per qualified bus write.
// Assumes: address is stable while the write is valid and data stays stable
// for at least three clocks after the write ends.
module fcd_write_qual #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [2:0] sync_q [SYNC_N];
    logic       act_q;
    logic       act_now;

    // Synchronizer chain for {ce_n, we_n, oe_n}; idle is all high.
    generate
        for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q[i] <= 3'b111;
                else if (i == 0)
                    sync_q[i] <= {ce_n, we_n, oe_n};
                else
                    sync_q[i] <= sync_q[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    // A write is valid with chip and write enable low and output enable high.
    assign act_now = !sync_q[SYNC_N-1][2] && !sync_q[SYNC_N-1][1] && sync_q[SYNC_N-1][0];

    // Edge tracking, address capture at start and data capture at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            act_q  <= act_now;
            wr_stb <= act_q && !act_now;
            if (act_now && !act_q)
                wr_addr <= addr;
            if (act_q && !act_now)
                wr_data <= wdata;
        end
    end

    AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);                                            // R14

endmodule

// File: rtl/fcd_sect_map.sv
// Module: picks the sector index from the top address bits.
// Assumes equal-size sectors and that word mode ignores the top byte-address bit.
module fcd_sect_map #(
    parameter int SECT_W = 4
) (
    input  logic              byte_mode,
    input  logic [SECT_W:0]   top_bits,
    output logic [SECT_W-1:0] sect
);

    // Byte mode: sector is the top SECT_W bits; word mode: one bit lower.
    always_comb begin
        sect = byte_mode ? top_bits[SECT_W:1] : top_bits[SECT_W-1:0];
    end

endmodule

// File: rtl/fcd_id_rom.sv
// Module: identification word for the current address in identification mode.
// Assumes offsets sit in the low address bits and the sector index comes from outside.
module fcd_id_rom #(
    parameter int          DATA_W   = 16,
    parameter int          NUM_SECT = 16,
    parameter int          SECT_W   = 4,
    parameter logic [15:0] DEV_ID   = 16'h22EA
) (
    input  logic                enable,
    input  logic                byte_mode,
    input  logic [8:0]          addr_lo,
    input  logic [SECT_W-1:0]   sect,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic [DATA_W-1:0]   id_data
);

    logic [7:0] offset;

    // Offset decode, then the identification word or zero.
    always_comb begin
        offset  = byte_mode ? addr_lo[8:1] : addr_lo[7:0];
        id_data = '0;
        if (enable) begin
            case (offset)
                8'd0:    id_data = DATA_W'(16'h00C2);
                8'd1:    id_data = byte_mode ? DATA_W'(DEV_ID[7:0]) : DATA_W'(DEV_ID);
                8'd2:    id_data = DATA_W'(sect_prot[sect]);
                default: id_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
// Module: follows unlock and command cycles, issues command events and holds
// the read mode. Assumes one write pulse at most every other clock.
module fcd_seq_fsm #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              op_busy,
    input  logic              op_fail,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              evt_valid,
    output logic [3:0]        evt_cmd,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [DATA_W-1:0] evt_data,
    output logic [1:0]        mode
);
    import fcd_pkg::*;

    fcd_seq_e   seq_q, seq_d;
    fcd_rmode_e mode_q, mode_d;
    fcd_evt_e   ev_d;
    logic       blocked;
    logic [7:0] code;
    logic       hit_k1, hit_k2, hit_q;

    assign blocked = op_busy && !op_fail;
    assign code    = wr_data[7:0];
    assign hit_k1  = adr_hit(wr_addr[11:0], byte_mode, W_KEY1_ADR, B_KEY1_ADR);
    assign hit_k2  = adr_hit(wr_addr[11:0], byte_mode, W_KEY2_ADR, B_KEY2_ADR);
    assign hit_q   = adr_hit(wr_addr[11:0], byte_mode, W_QUERY_ADR, B_QUERY_ADR);

    // Next-state decode of one write against the expected sequence step.
    always_comb begin
        seq_d  = seq_q;
        mode_d = mode_q;
        ev_d   = EV_NONE;
        if (wr_stb) begin
            if (blocked) begin
                if (code == CODE_SUSPEND) ev_d = EV_SUSPEND;
            end else if (code == CODE_RESET && seq_q != SQ_PROG) begin
                ev_d   = EV_RESET;
                seq_d  = SQ_IDLE;
                mode_d = RM_ARRAY;
            end else begin
                seq_d = SQ_IDLE;
                case (seq_q)
                    SQ_IDLE: begin
                        if (code == CODE_KEY1 && hit_k1)
                            seq_d = SQ_UNL1;
                        else if (code == CODE_QUERY && hit_q) begin
                            ev_d   = EV_CFI;
                            mode_d = RM_CFI;
                        end else if (code == CODE_SUSPEND)
                            ev_d = EV_SUSPEND;
                        else if (code == CODE_SECT)
                            ev_d = EV_RESUME;
                    end
                    SQ_UNL1: begin
                        if (code == CODE_KEY2 && hit_k2) seq_d = SQ_UNL2;
                        else mode_d = RM_ARRAY;
                    end
                    SQ_UNL2: begin
                        if (hit_k1 && code == CODE_PROG)
                            seq_d = SQ_PROG;
                        else if (hit_k1 && code == CODE_ESETUP)
                            seq_d = SQ_ESET;
                        else if (hit_k1 && code == CODE_IDENT) begin
                            ev_d   = EV_AUTOSEL;
                            mode_d = RM_AUTOSEL;
                        end else
                            mode_d = RM_ARRAY;
                    end
                    SQ_PROG: begin
                        ev_d   = EV_PROGRAM;
                        mode_d = RM_ARRAY;
                    end
                    SQ_ESET: begin
                        if (code == CODE_KEY1 && hit_k1) seq_d = SQ_EUNL1;
                        else mode_d = RM_ARRAY;
                    end
                    SQ_EUNL1: begin
                        if (code == CODE_KEY2 && hit_k2) seq_d = SQ_EUNL2;
                        else mode_d = RM_ARRAY;
                    end
                    SQ_EUNL2: begin
                        mode_d = RM_ARRAY;
                        if (code == CODE_CHIP && hit_k1) ev_d = EV_CHIP_ERASE;
                        else if (code == CODE_SECT)      ev_d = EV_SECTOR_ERASE;
                    end
                    default: mode_d = RM_ARRAY;
                endcase
            end
        end
    end

    // State, mode and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= SQ_IDLE;
            mode_q    <= RM_ARRAY;
            evt_valid <= 1'b0;
            evt_cmd   <= EV_NONE;
            evt_addr  <= '0;
            evt_data  <= '0;
        end else begin
            seq_q     <= seq_d;
            mode_q    <= mode_d;
            evt_valid <= (ev_d != EV_NONE);
            evt_cmd   <= ev_d;
            if (ev_d != EV_NONE) begin
                evt_addr <= wr_addr;
                evt_data <= wr_data;
            end
        end
    end

    assign mode = mode_q;

    AST_EVT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(wr_stb));                                   // R1
    AST_BLOCKED_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && blocked) |=> (!evt_valid || evt_cmd == EV_SUSPEND)); // R10
    AST_RESET_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cmd == EV_RESET) |-> (mode_q == RM_ARRAY && seq_q == SQ_IDLE)); // R9
    AST_AUTOSEL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cmd == EV_AUTOSEL) |-> mode_q == RM_AUTOSEL); // R6
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);                                      // R14

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: top of the flash command decoder. Qualifies bus writes, follows
// command sequences, and presents events, read mode and identification data.
// Assumes ADDR_W >= 12 and NUM_SECT a power of two covering the top address bits.
module flash_cmd_decoder #(
    parameter int          ADDR_W   = 20,
    parameter int          DATA_W   = 16,
    parameter int          NUM_SECT = 16,
    parameter logic [15:0] DEV_ID   = 16'h22EA,
    localparam int         SECT_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                byte_mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                op_busy,
    input  logic                op_fail,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic                evt_valid,
    output logic [3:0]          evt_cmd,
    output logic [ADDR_W-1:0]   evt_addr,
    output logic [DATA_W-1:0]   evt_data,
    output logic [SECT_W-1:0]   evt_sector,
    output logic [1:0]          read_mode,
    output logic [DATA_W-1:0]   id_data
);
    import fcd_pkg::*;

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [1:0]        mode_q;
    logic [SECT_W-1:0] rd_sect;

    fcd_write_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(2)) u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .op_busy(op_busy), .op_fail(op_fail),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_addr(evt_addr),
        .evt_data(evt_data), .mode(mode_q));

    fcd_sect_map #(.SECT_W(SECT_W)) u_evt_sect (
        .byte_mode(byte_mode), .top_bits(evt_addr[ADDR_W-1 -: SECT_W+1]),
        .sect(evt_sector));

    fcd_sect_map #(.SECT_W(SECT_W)) u_rd_sect (
        .byte_mode(byte_mode), .top_bits(addr[ADDR_W-1 -: SECT_W+1]),
        .sect(rd_sect));

    fcd_id_rom #(.DATA_W(DATA_W), .NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .DEV_ID(DEV_ID)) u_id (
        .enable(mode_q == RM_AUTOSEL), .byte_mode(byte_mode), .addr_lo(addr[8:0]),
        .sect(rd_sect), .sect_prot(sect_prot), .id_data(id_data));

    // Status overrides the command mode while an operation is busy or failed.
    always_comb begin
        read_mode = (op_busy || op_fail) ? RM_STATUS : mode_q;
    end

    AST_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy || op_fail) |-> read_mode == RM_STATUS);               // R13

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        byte_mode = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        op_busy = 1'b0, op_fail = 1'b0;
    logic [15:0] sect_prot = 16'h0020;
    logic        evt_valid;
    logic [3:0]  evt_cmd;
    logic [19:0] evt_addr;
    logic [15:0] evt_data;
    logic [3:0]  evt_sector;
    logic [1:0]  read_mode;
    logic [15:0] id_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit prev_evt = 0;

    typedef struct {
        int          cmd;
        logic [19:0] a;
        logic [15:0] d;
        logic [3:0]  s;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .addr(addr), .wdata(wdata),
        .op_busy(op_busy), .op_fail(op_fail), .sect_prot(sect_prot),
        .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_addr(evt_addr),
        .evt_data(evt_data), .evt_sector(evt_sector),
        .read_mode(read_mode), .id_data(id_data));

    // Driver side: expected event into the scoreboard.
    task automatic expect_ev(input int cmd, input logic [19:0] a, input logic [15:0] d, input string req);
        exp_t e;
        e.cmd = cmd; e.a = a; e.d = d; e.req = req;
        e.s = byte_mode ? a[19:16] : a[18:15];
        sb.push_back(e);
    endtask

    // One bus write; kind 0 valid, 1 with oe_n low, 2 with ce_n high.
    task automatic bus_wr(input logic [19:0] a, input logic [15:0] d, input int kind = 0);
        @(negedge clk);
        addr = a; wdata = d;
        ce_n = (kind == 2);
        oe_n = (kind == 1) ? 1'b0 : 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [19:0] k1(); return byte_mode ? 20'hAAA : 20'h555; endfunction
    function automatic logic [19:0] k2(); return byte_mode ? 20'h555 : 20'h2AA; endfunction

    task automatic unlock();
        bus_wr(k1(), 16'h00AA);
        bus_wr(k2(), 16'h0055);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each event; also check single-cycle pulses.
    always @(negedge clk) begin
        if (prev_evt) begin
            n_tests++;
            if (evt_valid) begin
                n_fail++;
                $display("FAIL R14 evt_valid actual=1 expected=0 in cycle after event");
            end
        end
        prev_evt = rst_n && evt_valid;
        if (rst_n && evt_valid) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected event actual cmd=%0d expected none", evt_cmd);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (evt_cmd != e.cmd[3:0] || evt_addr != e.a || evt_data != e.d || evt_sector != e.s) begin
                    n_fail++;
                    $display("FAIL %s actual cmd=%0d a=%0h d=%0h s=%0d expected cmd=%0d a=%0h d=%0h s=%0d",
                             e.req, evt_cmd, evt_addr, evt_data, evt_sector, e.cmd, e.a, e.d, e.s);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset read_mode", read_mode, 0);
        chk("R14 reset evt_valid", evt_valid, 0);
        chk("R7 reset id_data", id_data, 0);

        // R3 word program, R2 word addresses
        unlock(); bus_wr(20'h555, 16'h00A0);
        expect_ev(1, 20'h12345, 16'hBEEF, "R3");
        bus_wr(20'h12345, 16'hBEEF);

        // R2 byte program
        byte_mode = 1'b1;
        unlock(); bus_wr(20'hAAA, 16'h00A0);
        expect_ev(1, 20'hABCDE, 16'h005A, "R2");
        bus_wr(20'hABCDE, 16'h005A);

        // R2 byte addresses in word mode are not unlock cycles
        byte_mode = 1'b0;
        bus_wr(20'hAAA, 16'h00AA); bus_wr(20'h555, 16'h0055);
        bus_wr(20'hAAA, 16'h00A0); bus_wr(20'h00100, 16'h1234);
        chk("R2 wrong-mode read_mode", read_mode, 0);

        // R4 chip erase
        unlock(); bus_wr(20'h555, 16'h0080); unlock();
        expect_ev(2, 20'h555, 16'h0010, "R4");
        bus_wr(20'h555, 16'h0010);

        // R5 sector erase word and byte
        unlock(); bus_wr(20'h555, 16'h0080); unlock();
        expect_ev(3, 20'h3A123, 16'h0030, "R5");
        bus_wr(20'h3A123, 16'h0030);
        byte_mode = 1'b1;
        unlock(); bus_wr(20'hAAA, 16'h0080); unlock();
        expect_ev(3, 20'hE0010, 16'h0030, "R5");
        bus_wr(20'hE0010, 16'h0030);
        byte_mode = 1'b0;

        // R6/R7 identification, word mode
        unlock();
        expect_ev(4, 20'h555, 16'h0090, "R6");
        bus_wr(20'h555, 16'h0090);
        chk("R6 read_mode", read_mode, 1);
        addr = 20'h00000; @(negedge clk); chk("R7 word mfr", id_data, 16'h00C2);
        addr = 20'h00001; @(negedge clk); chk("R7 word dev", id_data, 16'h22EA);
        addr = 20'h28002; @(negedge clk); chk("R7 word prot sector5", id_data, 16'h0001);
        addr = 20'h08002; @(negedge clk); chk("R7 word prot sector1", id_data, 16'h0000);
        bus_wr(20'h00000, 16'h0077);
        chk("R6 mode kept", read_mode, 1);
        expect_ev(6, 20'h01234, 16'h00F0, "R9");
        bus_wr(20'h01234, 16'h00F0);
        chk("R9 autosel exit", read_mode, 0);
        chk("R7 id_data zero", id_data, 0);

        // R7 byte mode identification
        byte_mode = 1'b1;
        unlock();
        expect_ev(4, 20'hAAA, 16'h0090, "R6");
        bus_wr(20'hAAA, 16'h0090);
        addr = 20'h00002; @(negedge clk); chk("R7 byte dev", id_data, 16'h00EA);
        addr = 20'h50004; @(negedge clk); chk("R7 byte prot", id_data, 16'h0001);
        addr = 20'h00000; @(negedge clk); chk("R7 byte mfr", id_data, 16'h00C2);
        expect_ev(6, 20'h00000, 16'h00F0, "R9");
        bus_wr(20'h00000, 16'h00F0);

        // R8 query entry, byte then word; wrong address ignored
        bus_wr(20'h055, 16'h0098);
        chk("R8 wrong addr", read_mode, 0);
        expect_ev(5, 20'h0AA, 16'h0098, "R8");
        bus_wr(20'h0AA, 16'h0098);
        chk("R8 byte mode", read_mode, 2);
        byte_mode = 1'b0;
        expect_ev(6, 20'h00000, 16'h00F0, "R9");
        bus_wr(20'h00000, 16'h00F0);
        expect_ev(5, 20'h055, 16'h0098, "R8");
        bus_wr(20'h055, 16'h0098);
        chk("R8 word mode", read_mode, 2);
        expect_ev(6, 20'h00000, 16'h00F0, "R9");
        bus_wr(20'h00000, 16'h00F0);

        // R1 disqualified strobes break the sequence
        bus_wr(20'h555, 16'h00AA, 1); bus_wr(20'h2AA, 16'h0055);
        bus_wr(20'h555, 16'h00A0); bus_wr(20'h00200, 16'h4444);
        bus_wr(20'h555, 16'h00AA); bus_wr(20'h2AA, 16'h0055, 2);
        bus_wr(20'h555, 16'h00A0); bus_wr(20'h00300, 16'h5555);
        chk("R1 no mode change", read_mode, 0);

        // R9 reset part way through sequences
        unlock();
        expect_ev(6, 20'h00010, 16'h00F0, "R9");
        bus_wr(20'h00010, 16'h00F0);
        unlock(); bus_wr(20'h555, 16'h0080);
        expect_ev(6, 20'h00020, 16'h00F0, "R9");
        bus_wr(20'h00020, 16'h00F0);

        // R12 abort on a bad command, and from identification mode
        unlock(); bus_wr(20'h555, 16'h0077);
        unlock();
        expect_ev(4, 20'h555, 16'h0090, "R12");
        bus_wr(20'h555, 16'h0090);
        bus_wr(20'h555, 16'h00AA); bus_wr(20'h2AA, 16'h0011);
        chk("R12 abort to array", read_mode, 0);
        unlock(); bus_wr(20'h555, 16'h00A0);
        expect_ev(1, 20'h00400, 16'h00FF, "R12");
        bus_wr(20'h00400, 16'h00FF);

        // R10/R13 busy gating
        op_busy = 1'b1;
        @(negedge clk);
        chk("R13 busy status", read_mode, 3);
        bus_wr(20'h00000, 16'h00F0);
        unlock(); bus_wr(20'h555, 16'h00A0); bus_wr(20'h00500, 16'h0001);
        expect_ev(7, 20'h00600, 16'h00B0, "R10");
        bus_wr(20'h00600, 16'h00B0);
        op_busy = 1'b0; op_fail = 1'b1;
        @(negedge clk);
        chk("R13 fail status", read_mode, 3);
        expect_ev(6, 20'h00700, 16'h00F0, "R9");
        bus_wr(20'h00700, 16'h00F0);
        op_fail = 1'b0;
        @(negedge clk);
        chk("R13 back to array", read_mode, 0);

        // R11 suspend and resume from idle
        expect_ev(7, 20'h12000, 16'h00B0, "R11");
        bus_wr(20'h12000, 16'h00B0);
        expect_ev(8, 20'h13000, 16'h0030, "R11");
        bus_wr(20'h13000, 16'h0030);

        repeat (10) @(negedge clk);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++; n_fail++;
            $display("FAIL %s actual=missing expected cmd=%0d", e.req, e.cmd);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule